// File: doc/BRIEF.md
# Audio Sample Buffer with Threshold DMA Requests

This block sits between a DMA engine and a serial audio port. It holds two independent first-in first-out sample stores, one per direction. The transmit store is filled by DMA writes and drained by the serializer one 32-bit slot at a time. The receive store is filled by the serializer and drained by DMA reads. Each direction raises a DMA request line from its fill level and a programmable threshold, so the DMA engine moves samples in bursts instead of one at a time.

A mode bit picks between per-sample operation and burst operation. In per-sample mode the effective threshold is one sample. In burst mode each direction uses its own threshold register. Software writes that register with the burst length in samples, less one. For 16-bit audio, the burst length is the transfer period in bytes divided by two. Each register saturates at its own maximum. The transmit request has hysteresis. Once raised, it stays up until the transmit store is completely full. This keeps the serializer from starving during start-up. Reading an empty transmit store and writing a full receive store are recorded in sticky error flags.

Top module: `audio_fifo_dreq`

## Requirements
- R1: Each direction is a first-in first-out store of DEPTH (default 1024) entries of 32 bits. Popped data appears on the pop data output in the cycle after the pop strobe and holds until the next pop.
- R2: tx_level and rx_level give the number of stored entries and follow accepted operations one cycle later. A push and a pop in the same cycle leave the level unchanged. A push to a full store is accepted when a pop to that store succeeds in the same cycle.
- R3: With the mode bit at 0 (per-sample mode), the effective threshold of both directions is 0, whatever the threshold registers hold.
- R4: With the mode bit at 1 (burst mode), the effective threshold is the value written to that direction's register, that is the sample count less one. A write above TX_THR_MAX (default 1023) or RX_THR_MAX (default 511) stores that maximum instead.
- R5: rx_dreq is high exactly when rx_level is at least the effective receive threshold plus one.
- R6: tx_dreq is high when the free space (DEPTH minus tx_level) is at least the effective transmit threshold plus one. Once high, it stays high until tx_level reaches DEPTH.
- R7: A transmit pop with the store empty returns zero on tx_pop_data, leaves the level unchanged and sets the sticky tx_underflow flag.
- R8: A receive push with the store full and no receive pop in the same cycle drops the sample, leaves the level unchanged and sets the sticky rx_overflow flag.
- R9: A transmit push to a full store with no pop in the same cycle is ignored without any flag. A receive pop of an empty store returns zero without changing rx_overflow.
- R10: Synchronous reset empties both stores, clears both flags and both pop data outputs, sets both threshold registers to 0 and the mode bit to 0, and holds both requests low while it is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode_we | input | 1 | Load strobe for the mode bit |
| cfg_mode_val | input | 1 | Mode: 0 per-sample, 1 burst |
| cfg_tx_thr_we | input | 1 | Load strobe for the transmit threshold |
| cfg_rx_thr_we | input | 1 | Load strobe for the receive threshold |
| cfg_thr_val | input | $clog2(DEPTH) | Threshold value (samples minus one) |
| tx_push | input | 1 | DMA write into the transmit store |
| tx_push_data | input | DW | Transmit sample written by DMA |
| tx_pop | input | 1 | Serializer takes one transmit slot |
| tx_pop_data | output | DW | Slot handed to the serializer |
| tx_level | output | $clog2(DEPTH+1) | Transmit fill level |
| tx_dreq | output | 1 | Transmit DMA request |
| tx_underflow | output | 1 | Sticky transmit underflow flag |
| rx_push | input | 1 | Serializer delivers one receive slot |
| rx_push_data | input | DW | Received slot |
| rx_pop | input | 1 | DMA read from the receive store |
| rx_pop_data | output | DW | Sample returned to DMA |
| rx_level | output | $clog2(DEPTH+1) | Receive fill level |
| rx_dreq | output | 1 | Receive DMA request |
| rx_overflow | output | 1 | Sticky receive overflow flag |

## Verification
The hardest situation to reach is the transmit hold window. The request must stay up through every level from its rise to the 1024th entry, and then stay down while the store drains until free space again exceeds the threshold. The stimulus reaches it with long directed push and pop runs and checks the request at every level on the way. Receive overflow and the saturated receive threshold also need the store filled to the brim, so directed runs fill it completely. Constrained random phases then bias toward filling or draining, mixing thresholds and mode changes, so that both flags and both requests flip many times against a queue-based model.

// File: rtl/aud_fifo_pkg.sv
`timescale 1ns/1ps
package aud_fifo_pkg;

    // Request operating mode
    typedef enum logic {
        MODE_PER_SAMPLE = 1'b0,
        MODE_BURST      = 1'b1
    } xfer_mode_e;

    // Which misuse of a store raises its sticky flag
    typedef enum logic {
        FLAG_EMPTY_POP = 1'b0,
        FLAG_FULL_PUSH = 1'b1
    } err_kind_e;

    // Per-cycle operation outcome of one store
    typedef struct packed {
        logic pop_ok;
        logic push_ok;
        logic misuse;
    } fifo_op_t;

    // Saturate a requested threshold to its programmable ceiling
    function automatic int unsigned sat_thr(input int unsigned val,
                                            input int unsigned ceil_v);
        return (val > ceil_v) ? ceil_v : val;
    endfunction

    // Advance a circular index
    function automatic int unsigned wrap_inc(input int unsigned idx,
                                             input int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/afd_cfg.sv
`timescale 1ns/1ps
module afd_cfg
    import aud_fifo_pkg::*;
#(
    parameter int TW     = 10,
    parameter int TX_MAX = 1023,
    parameter int RX_MAX = 511
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_we,
    input  logic          mode_val,
    input  logic          tx_thr_we,
    input  logic          rx_thr_we,
    input  logic [TW-1:0] thr_val,
    output logic [TW-1:0] tx_thr_eff,
    output logic [TW-1:0] rx_thr_eff
);
    localparam logic [TW-1:0] TX_MAX_V = TW'(TX_MAX);
    localparam logic [TW-1:0] RX_MAX_V = TW'(RX_MAX);

    xfer_mode_e    mode_q;
    logic [TW-1:0] tx_thr_q;
    logic [TW-1:0] rx_thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_PER_SAMPLE;
            tx_thr_q <= '0;
            rx_thr_q <= '0;
        end else begin
            if (mode_we)
                mode_q <= xfer_mode_e'(mode_val);
            if (tx_thr_we)
                tx_thr_q <= TW'(sat_thr(int'(thr_val), int'(TX_MAX_V)));
            if (rx_thr_we)
                rx_thr_q <= TW'(sat_thr(int'(thr_val), int'(RX_MAX_V)));
        end
    end

    always_comb begin
        if (mode_q == MODE_BURST) begin
            tx_thr_eff = tx_thr_q;
            rx_thr_eff = rx_thr_q;
        end else begin
            tx_thr_eff = '0;
            rx_thr_eff = '0;
        end
    end

    // R4
    thr_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_thr_eff <= TX_MAX_V) && (rx_thr_eff <= RX_MAX_V));

    // R3
    per_sample_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_we && !mode_val) |=> (tx_thr_eff == '0 && rx_thr_eff == '0));

endmodule

// File: rtl/afd_fifo.sv
`timescale 1ns/1ps
module afd_fifo
    import aud_fifo_pkg::*;
#(
    parameter int        DEPTH    = 1024,
    parameter int        DW       = 32,
    parameter err_kind_e ERR_KIND = FLAG_EMPTY_POP,
    localparam int       AW       = $clog2(DEPTH),
    localparam int       LW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [LW-1:0] level,
    output logic          err_flag
);
    localparam logic [LW-1:0] FULL_L = LW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [LW-1:0] level_q;
    logic          err_q;
    logic [DW-1:0] pop_data_q;
    logic          empty;
    logic          full;
    fifo_op_t      op;

    assign empty = (level_q == '0);
    assign full  = (level_q == FULL_L);

    always_comb begin
        op.pop_ok  = pop && !empty;
        op.push_ok = push && (!full || op.pop_ok);
    end

    generate
        if (ERR_KIND == FLAG_EMPTY_POP) begin : g_under
            always_comb op.misuse = pop && empty;
        end else begin : g_over
            always_comb op.misuse = push && !op.push_ok;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (op.push_ok)
            mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            level_q    <= '0;
            err_q      <= 1'b0;
            pop_data_q <= '0;
        end else begin
            if (op.push_ok)
                wr_ptr <= AW'(wrap_inc(int'(wr_ptr), DEPTH));
            if (op.pop_ok)
                rd_ptr <= AW'(wrap_inc(int'(rd_ptr), DEPTH));
            if (pop)
                pop_data_q <= op.pop_ok ? mem[rd_ptr] : '0;
            if (op.push_ok && !op.pop_ok)
                level_q <= level_q + LW'(1);
            else if (op.pop_ok && !op.push_ok)
                level_q <= level_q - LW'(1);
            if (op.misuse)
                err_q <= 1'b1;
        end
    end

    assign level    = level_q;
    assign err_flag = err_q;
    assign pop_data = pop_data_q;

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_L);

    // R7 R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R7
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && level == '0) |=> (pop_data == '0));

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && level == FULL_L) |=> (level == FULL_L));

endmodule

// File: rtl/afd_req.sv
`timescale 1ns/1ps
module afd_req #(
    parameter int DEPTH    = 1024,
    parameter bit HOLD     = 1'b0,
    localparam int TW      = $clog2(DEPTH),
    localparam int LW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] level,
    input  logic [TW-1:0] thr,
    output logic          dreq
);
    localparam logic [LW-1:0] FULL_L = LW'(DEPTH);

    logic [LW-1:0] need;
    assign need = LW'(thr) + LW'(1);

    generate
        if (HOLD) begin : g_fill_to_full
            logic [LW-1:0] space;
            logic          hold_q;
            assign space = FULL_L - level;
            assign dreq  = !rst && ((space >= need) || (hold_q && level != FULL_L));

            always_ff @(posedge clk) begin
                if (rst) hold_q <= 1'b0;
                else     hold_q <= dreq;
            end

            // R6
            full_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
                (level == FULL_L) |-> !dreq);

            // R6
            req_holds_chk: assert property (@(posedge clk) disable iff (rst)
                dreq |=> (dreq || level == FULL_L));
        end else begin : g_level
            assign dreq = !rst && (level >= need);
        end
    endgenerate

endmodule

// File: rtl/audio_fifo_dreq.sv
`timescale 1ns/1ps
module audio_fifo_dreq
    import aud_fifo_pkg::*;
#(
    parameter int DEPTH      = 1024,
    parameter int DW         = 32,
    parameter int TX_THR_MAX = 1023,
    parameter int RX_THR_MAX = 511
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_mode_we,
    input  logic                       cfg_mode_val,
    input  logic                       cfg_tx_thr_we,
    input  logic                       cfg_rx_thr_we,
    input  logic [$clog2(DEPTH)-1:0]   cfg_thr_val,
    input  logic                       tx_push,
    input  logic [DW-1:0]              tx_push_data,
    input  logic                       tx_pop,
    output logic [DW-1:0]              tx_pop_data,
    output logic [$clog2(DEPTH+1)-1:0] tx_level,
    output logic                       tx_dreq,
    output logic                       tx_underflow,
    input  logic                       rx_push,
    input  logic [DW-1:0]              rx_push_data,
    input  logic                       rx_pop,
    output logic [DW-1:0]              rx_pop_data,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic                       rx_dreq,
    output logic                       rx_overflow
);
    localparam int TW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [TW-1:0] tx_thr_eff;
    logic [TW-1:0] rx_thr_eff;

    afd_cfg #(.TW(TW), .TX_MAX(TX_THR_MAX), .RX_MAX(RX_THR_MAX)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .mode_we    (cfg_mode_we),
        .mode_val   (cfg_mode_val),
        .tx_thr_we  (cfg_tx_thr_we),
        .rx_thr_we  (cfg_rx_thr_we),
        .thr_val    (cfg_thr_val),
        .tx_thr_eff (tx_thr_eff),
        .rx_thr_eff (rx_thr_eff)
    );

    afd_fifo #(.DEPTH(DEPTH), .DW(DW), .ERR_KIND(FLAG_EMPTY_POP)) u_tx_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .level     (tx_level),
        .err_flag  (tx_underflow)
    );

    afd_fifo #(.DEPTH(DEPTH), .DW(DW), .ERR_KIND(FLAG_FULL_PUSH)) u_rx_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .pop_data  (rx_pop_data),
        .level     (rx_level),
        .err_flag  (rx_overflow)
    );

    afd_req #(.DEPTH(DEPTH), .HOLD(1'b1)) u_tx_req (
        .clk   (clk),
        .rst   (rst),
        .level (tx_level),
        .thr   (tx_thr_eff),
        .dreq  (tx_dreq)
    );

    afd_req #(.DEPTH(DEPTH), .HOLD(1'b0)) u_rx_req (
        .clk   (clk),
        .rst   (rst),
        .level (rx_level),
        .thr   (rx_thr_eff),
        .dreq  (rx_dreq)
    );

    // R5
    rx_req_level_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_level > LW'(rx_thr_eff)) |-> rx_dreq);

    // R5
    rx_req_low_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_level <= LW'(rx_thr_eff)) |-> !rx_dreq);

endmodule

// File: tb/audio_fifo_dreq_tb.sv
`timescale 1ns/1ps
module audio_fifo_dreq_tb;
    localparam int DEPTH = 1024;
    localparam int DW    = 32;
    localparam int TXM   = 1023;
    localparam int RXM   = 511;
    localparam int TW    = $clog2(DEPTH);
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst;
    logic          cfg_mode_we, cfg_mode_val, cfg_tx_thr_we, cfg_rx_thr_we;
    logic [TW-1:0] cfg_thr_val;
    logic          tx_push, tx_pop, rx_push, rx_pop;
    logic [DW-1:0] tx_push_data, rx_push_data, tx_pop_data, rx_pop_data;
    logic [LW-1:0] tx_level, rx_level;
    logic          tx_dreq, rx_dreq, tx_underflow, rx_overflow;

    audio_fifo_dreq #(.DEPTH(DEPTH), .DW(DW), .TX_THR_MAX(TXM), .RX_THR_MAX(RXM)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_mode_we(cfg_mode_we), .cfg_mode_val(cfg_mode_val),
        .cfg_tx_thr_we(cfg_tx_thr_we), .cfg_rx_thr_we(cfg_rx_thr_we),
        .cfg_thr_val(cfg_thr_val),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_level(tx_level), .tx_dreq(tx_dreq),
        .tx_underflow(tx_underflow),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_level(rx_level), .rx_dreq(rx_dreq),
        .rx_overflow(rx_overflow)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    logic [DW-1:0] tq[$];
    logic [DW-1:0] rq[$];
    bit            m_hold, m_uf, m_of, m_mode;
    int            m_tthr, m_rthr;
    logic [DW-1:0] m_trd, m_rrd;

    // stimulus for the next cycle
    bit            s_tw, s_tr, s_rw, s_rr, s_mwe, s_mval, s_twe, s_rwe;
    logic [DW-1:0] s_td, s_rd;
    int            s_thr;

    function automatic int eff_t();
        return m_mode ? m_tthr : 0;
    endfunction

    function automatic int eff_r();
        return m_mode ? m_rthr : 0;
    endfunction

    function automatic bit tx_req_f(int lvl, bit hold, int thr);
        return ((DEPTH - lvl) >= thr + 1) || (hold && lvl != DEPTH);
    endfunction

    function automatic bit rx_req_f(int lvl, int thr);
        return lvl >= thr + 1;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic compare_all();
        chk("R2", "tx_level", tx_level, tq.size());
        chk("R2", "rx_level", rx_level, rq.size());
        chk("R6", "tx_dreq", tx_dreq, tx_req_f(tq.size(), m_hold, eff_t()));
        chk("R5", "rx_dreq", rx_dreq, rx_req_f(rq.size(), eff_r()));
        chk("R7", "tx_underflow", tx_underflow, m_uf);
        chk("R8", "rx_overflow", rx_overflow, m_of);
        chk("R1", "tx_pop_data", tx_pop_data, m_trd);
        chk("R1", "rx_pop_data", rx_pop_data, m_rrd);
    endtask

    task automatic clear_stim();
        s_tw = 0; s_tr = 0; s_rw = 0; s_rr = 0;
        s_mwe = 0; s_mval = 0; s_twe = 0; s_rwe = 0;
        s_td = '0; s_rd = '0; s_thr = 0;
    endtask

    // one clock: drive at negedge, model after posedge, compare at next negedge
    task automatic tick();
        bit tr_ok, tw_ok, rr_ok, rw_ok, new_hold;
        tx_push = s_tw; tx_push_data = s_td; tx_pop = s_tr;
        rx_push = s_rw; rx_push_data = s_rd; rx_pop = s_rr;
        cfg_mode_we = s_mwe; cfg_mode_val = s_mval;
        cfg_tx_thr_we = s_twe; cfg_rx_thr_we = s_rwe; cfg_thr_val = TW'(s_thr);
        @(posedge clk);
        #1;
        new_hold = tx_req_f(tq.size(), m_hold, eff_t());
        tr_ok = s_tr && tq.size() > 0;
        tw_ok = s_tw && (tq.size() < DEPTH || tr_ok);
        if (s_tr) begin
            if (tr_ok) m_trd = tq.pop_front();
            else begin m_trd = '0; m_uf = 1; end
        end
        if (tw_ok) tq.push_back(s_td);
        m_hold = new_hold;
        rr_ok = s_rr && rq.size() > 0;
        rw_ok = s_rw && (rq.size() < DEPTH || rr_ok);
        if (s_rr) m_rrd = rr_ok ? rq.pop_front() : '0;
        if (rw_ok) rq.push_back(s_rd);
        else if (s_rw) m_of = 1;
        if (s_mwe) m_mode = s_mval;
        if (s_twe) m_tthr = (s_thr > TXM) ? TXM : s_thr;
        if (s_rwe) m_rthr = (s_thr > RXM) ? RXM : s_thr;
        @(negedge clk);
        compare_all();
        clear_stim();
    endtask

    task automatic do_reset();
        clear_stim();
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        cfg_mode_we = 0; cfg_mode_val = 0; cfg_tx_thr_we = 0; cfg_rx_thr_we = 0;
        cfg_thr_val = '0; tx_push_data = '0; rx_push_data = '0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10", "tx_level in reset", tx_level, 0);
        chk("R10", "rx_level in reset", rx_level, 0);
        chk("R10", "tx_dreq in reset", tx_dreq, 0);
        chk("R10", "rx_dreq in reset", rx_dreq, 0);
        chk("R10", "flags in reset", {tx_underflow, rx_overflow}, 0);
        chk("R10", "pop data in reset", {tx_pop_data, rx_pop_data}, 0);
        rst = 1'b0;
        tq.delete(); rq.delete();
        m_hold = 0; m_uf = 0; m_of = 0; m_mode = 0;
        m_tthr = 0; m_rthr = 0; m_trd = '0; m_rrd = '0;
        #1;
        chk("R10", "tx_dreq after release (empty store)", tx_dreq, 1);
        chk("R10", "rx_dreq after release", rx_dreq, 0);
    endtask

    task automatic set_cfg(bit mode, int tthr, int rthr);
        s_mwe = 1; s_mval = mode; s_twe = 1; s_thr = tthr; tick();
        s_rwe = 1; s_thr = rthr; tick();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_a0d1));
        do_reset();

        // R3: per-sample mode, threshold registers loaded but ignored
        s_twe = 1; s_thr = 40; tick();
        s_rwe = 1; s_thr = 40; tick();
        s_rw = 1; s_rd = 32'hA5A5_0001; tick();
        chk("R3", "rx_dreq after one sample in per-sample mode", rx_dreq, 1);

        // R4: burst mode uses the stored threshold (3 -> four samples)
        do_reset();
        set_cfg(1'b1, 7, 3);
        for (int i = 0; i < 3; i++) begin s_rw = 1; s_rd = 32'h100 + i; tick(); end
        chk("R4", "rx_dreq at three samples, threshold 3", rx_dreq, 0);
        s_rw = 1; s_rd = 32'h103; tick();
        chk("R4", "rx_dreq at four samples, threshold 3", rx_dreq, 1);

        // R4: receive threshold saturates at RXM
        s_rwe = 1; s_thr = 900; tick();
        while (rq.size() < RXM) begin s_rw = 1; s_rd = 32'h2000 + rq.size(); tick(); end
        chk("R4", "rx_dreq at 511 with saturated threshold", rx_dreq, 0);
        s_rw = 1; s_rd = 32'hBEEF; tick();
        chk("R4", "rx_dreq at 512 with saturated threshold", rx_dreq, 1);

        // R8: fill receive store and overflow it
        while (rq.size() < DEPTH) begin s_rw = 1; s_rd = 32'h3000 + rq.size(); tick(); end
        chk("R8", "rx_overflow before overflow", rx_overflow, 0);
        s_rw = 1; s_rd = 32'hDEAD_DEAD; tick();
        chk("R8", "rx_overflow after full push", rx_overflow, 1);
        chk("R8", "rx_level stays full", rx_level, DEPTH);
        // R2: push and pop together on a full store
        s_rw = 1; s_rd = 32'h7777; s_rr = 1; tick();
        chk("R2", "rx_level after push+pop at full", rx_level, DEPTH);
        // R1: drain in order
        while (rq.size() > 0) begin s_rr = 1; tick(); end
        // R9: pop of empty receive store
        s_rr = 1; tick();
        chk("R9", "rx_pop_data on empty pop", rx_pop_data, 0);
        chk("R9", "rx_overflow unchanged by empty pop", rx_overflow, 1);

        // R6: transmit fills to full with hold
        do_reset();
        set_cfg(1'b1, 7, 0);
        while (tq.size() < DEPTH - 1) begin s_tw = 1; s_td = 32'h4000 + tq.size(); tick(); end
        chk("R6", "tx_dreq held at 1023 entries", tx_dreq, 1);
        s_tw = 1; s_td = 32'h4FFF; tick();
        chk("R6", "tx_dreq drops at full", tx_dreq, 0);
        // R9: push to full transmit store ignored, no flag
        s_tw = 1; s_td = 32'hBAD0_BAD0; tick();
        chk("R9", "tx_level after push to full", tx_level, DEPTH);
        chk("R9", "tx_underflow after push to full", tx_underflow, 0);
        while (tq.size() > DEPTH - 7) begin s_tr = 1; tick(); end
        chk("R6", "tx_dreq with 7 free, threshold 7", tx_dreq, 0);
        s_tr = 1; tick();
        chk("R6", "tx_dreq with 8 free, threshold 7", tx_dreq, 1);

        // R7: drain and underflow
        while (tq.size() > 0) begin s_tr = 1; tick(); end
        s_tr = 1; tick();
        chk("R7", "tx_pop_data on empty pop", tx_pop_data, 0);
        chk("R7", "tx_underflow set", tx_underflow, 1);
        chk("R7", "tx_level unchanged", tx_level, 0);
        // R7: push and pop together on empty store
        s_tr = 1; s_tw = 1; s_td = 32'h5555; tick();
        chk("R7", "tx_level after empty pop with push", tx_level, 1);

        // constrained random phases: fill-biased, drain-biased, balanced
        do_reset();
        for (int ph = 0; ph < 3; ph++) begin
            int pw = (ph == 0) ? 80 : (ph == 1) ? 20 : 50;
            for (int c = 0; c < 12000; c++) begin
                s_tw = ($urandom % 100) < pw;
                s_tr = ($urandom % 100) < (100 - pw);
                s_rw = ($urandom % 100) < pw;
                s_rr = ($urandom % 100) < (100 - pw);
                s_td = $urandom;
                s_rd = $urandom;
                if (($urandom % 500) == 0) begin
                    s_mwe = 1; s_mval = $urandom % 2;
                end
                if (($urandom % 300) == 0) begin
                    s_thr = $urandom % DEPTH;
                    s_twe = $urandom % 2;
                    s_rwe = !s_twe;
                end
                tick();
            end
        end

        finish_run();
    end
endmodule